// File: doc/BRIEF.md
# Signed Nibble Sign-and-Digit Display Driver

This block takes a four-bit two's complement number and produces the segment drive for a pair of seven-segment displays. Together they show the number's signed decimal value. The left display serves only as a minus sign. The right display shows the magnitude as one decimal digit from 0 to 8.

The block is purely combinational. It has no clock and no state, so its outputs follow the input within the same cycle. A surrounding design can feed it a register value directly and wire both segment buses to the display pins. Segments are active high.

Top module: `signed_nibble_display`

## Requirements
- R1: `nib_in` is read as a two's complement value with bit 3 as the most significant bit, so codes 0000 to 0111 mean 0 to +7 and codes 1000 to 1111 mean -8 to -1.
- R2: Bit 6 of `sign_seg` is the middle segment g. It is 1 exactly when `nib_in[3]` is 1, meaning the value is negative.
- R3: Bits 5 to 0 of `sign_seg` (segments f, e, d, c, b, a) are 0 for every input value.
- R4: `digit_seg` shows the absolute value of the input. Bit 0 is segment a, bit 1 is b, and so on up to bit 6, which is g. The glyph codes are: 0 = 7'h3F, 1 = 7'h06, 2 = 7'h5B, 3 = 7'h4F, 4 = 7'h66, 5 = 7'h6D, 6 = 7'h7D (with the top tail), 7 = 7'h07, 8 = 7'h7F.
- R5: Input 1000 (-8) shows the minus sign and the glyph 8 (7'h7F). The magnitude must not wrap to 0.
- R6: Input 0000 shows the glyph 0 with the sign display fully dark (`sign_seg` = 7'h00).
- R7: The outputs depend only on the current input. A change on `nib_in` shows up on both buses without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| nib_in | input | 4 | Two's complement value to display, bit 3 is the MSB |
| sign_seg | output | 7 | Sign display segments, bit 0 = a through bit 6 = g, active high |
| digit_seg | output | 7 | Magnitude display segments, bit 0 = a through bit 6 = g, active high |

## Verification
The bench targets four corner cases:

- **-8.** A negation that keeps only the low three bits would display 0 with a minus sign, or a blank digit.
- **-1.** An error in the negate-by-invert-and-add step would show 0 or 2 instead of 1.
- **Zero.** A sign taken from anything other than the MSB, or a leftover bit lit on the sign display, would show a stray minus.
- **Glyph 6.** A design that uses the tailless form would drop segment a.

Every one of the sixteen input codes is compared against both buses. The bench also changes the input between clock edges, which exposes any design that waits for a clock before updating.

// File: rtl/snd_pkg.sv
package snd_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_W = 7;
    localparam int MAG_W = NIB_W;
    localparam int MAX_MAG = 1 << (NIB_W - 1);

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [MAG_W-1:0] mag_t;

    // Segment index: bit position within a segment bus.
    typedef enum int {
        SEG_A = 0,
        SEG_B = 1,
        SEG_C = 2,
        SEG_D = 3,
        SEG_E = 4,
        SEG_F = 5,
        SEG_G = 6
    } seg_idx_e;

    typedef struct packed {
        logic neg;
        mag_t mag;
    } split_t;

    // Active-high glyph for a decimal digit 0..8; blank otherwise.
    function automatic seg_t glyph_of(input mag_t m);
        seg_t s;
        s = '0;
        case (m)
            4'd0: s = 7'h3F;
            4'd1: s = 7'h06;
            4'd2: s = 7'h5B;
            4'd3: s = 7'h4F;
            4'd4: s = 7'h66;
            4'd5: s = 7'h6D;
            4'd6: s = 7'h7D;
            4'd7: s = 7'h07;
            4'd8: s = 7'h7F;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nib_split.sv
module nib_split
    import snd_pkg::*;
(
    input  logic [NIB_W-1:0] val_i,
    output logic             neg_o,
    output mag_t             mag_o
);

    split_t split_d;

    always_comb begin
        split_d.neg = val_i[NIB_W-1];
        // Negate at full width so the most negative code keeps its magnitude.
        if (split_d.neg) begin
            split_d.mag = mag_t'(~val_i) + mag_t'(1);
        end else begin
            split_d.mag = mag_t'(val_i);
        end
    end

    assign neg_o = split_d.neg;
    assign mag_o = split_d.mag;

    // R4: magnitude never exceeds the most negative value's size
    always_comb begin
        if (!$isunknown(val_i)) begin
            a_r4_mag_range: assert (int'(mag_o) <= MAX_MAG)
                else $error("R4 magnitude out of range: %0d", mag_o);
        end
    end

    // R5: most negative code keeps full magnitude
    always_comb begin
        if (!$isunknown(val_i) && val_i == {1'b1, {(NIB_W-1){1'b0}}}) begin
            a_r5_no_overflow: assert (int'(mag_o) == MAX_MAG)
                else $error("R5 magnitude wrapped: %0d", mag_o);
        end
    end

endmodule

// File: rtl/glyph_enc.sv
module glyph_enc
    import snd_pkg::*;
(
    input  mag_t mag_i,
    output seg_t seg_o
);

    seg_t seg_d;

    always_comb begin
        seg_d = glyph_of(mag_i);
    end

    assign seg_o = seg_d;

    // R4: every reachable digit lights at least two segments
    always_comb begin
        if (!$isunknown(mag_i) && int'(mag_i) <= MAX_MAG) begin
            a_r4_glyph_lit: assert ($countones(seg_o) >= 2)
                else $error("R4 glyph too dark for %0d", mag_i);
        end
    end

endmodule

// File: rtl/sign_enc.sv
module sign_enc
    import snd_pkg::*;
(
    input  logic neg_i,
    output seg_t seg_o
);

    seg_t seg_d;

    // Only the middle bar may ever be driven.
    for (genvar i = 0; i < SEG_W; i++) begin : g_seg
        if (i == SEG_G) begin : g_mid
            always_comb seg_d[i] = neg_i;
        end else begin : g_dark
            always_comb seg_d[i] = 1'b0;
        end
    end

    assign seg_o = seg_d;

endmodule

// File: rtl/signed_nibble_display.sv
module signed_nibble_display
    import snd_pkg::*;
(
    input  logic [3:0] nib_in,
    output logic [6:0] sign_seg,
    output logic [6:0] digit_seg
);

    logic neg_w;
    mag_t mag_w;

    nib_split u_split (
        .val_i (nib_in),
        .neg_o (neg_w),
        .mag_o (mag_w)
    );

    sign_enc u_sign (
        .neg_i (neg_w),
        .seg_o (sign_seg)
    );

    glyph_enc u_glyph (
        .mag_i (mag_w),
        .seg_o (digit_seg)
    );

    always_comb begin
        if (!$isunknown(nib_in)) begin
            // R2: minus bar follows the input MSB
            a_r2_sign_follows_msb: assert (sign_seg[SEG_G] == nib_in[3])
                else $error("R2 minus bar mismatch");
            // R3: the rest of the sign display stays dark
            a_r3_sign_rest_dark: assert (sign_seg[SEG_F:SEG_A] == '0)
                else $error("R3 stray sign segment");
            // R6: zero shows 0 without a minus
            if (nib_in == 4'b0000) begin
                a_r6_zero_plain: assert (sign_seg == '0 && digit_seg == 7'h3F)
                    else $error("R6 zero display wrong");
            end
            // R5: -8 shows minus and full glyph
            if (nib_in == 4'b1000) begin
                a_r5_min_neg_glyph: assert (digit_seg == 7'h7F && sign_seg[SEG_G])
                    else $error("R5 -8 display wrong");
            end
        end
    end

endmodule

// File: tb/tb_signed_nibble_display.sv
module tb_signed_nibble_display;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 16;

    // {input, expected sign bus, expected digit bus}
    localparam logic [17:0] VEC [0:N_VEC-1] = '{
        {4'h0, 7'h00, 7'h3F},
        {4'h1, 7'h00, 7'h06},
        {4'h2, 7'h00, 7'h5B},
        {4'h3, 7'h00, 7'h4F},
        {4'h4, 7'h00, 7'h66},
        {4'h5, 7'h00, 7'h6D},
        {4'h6, 7'h00, 7'h7D},
        {4'h7, 7'h00, 7'h07},
        {4'h8, 7'h40, 7'h7F},
        {4'h9, 7'h40, 7'h07},
        {4'hA, 7'h40, 7'h7D},
        {4'hB, 7'h40, 7'h6D},
        {4'hC, 7'h40, 7'h66},
        {4'hD, 7'h40, 7'h4F},
        {4'hE, 7'h40, 7'h5B},
        {4'hF, 7'h40, 7'h06}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] nib_in = 4'h0;
    logic [6:0] sign_seg;
    logic [6:0] digit_seg;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    signed_nibble_display dut (
        .nib_in    (nib_in),
        .sign_seg  (sign_seg),
        .digit_seg (digit_seg)
    );

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s in=%h actual=%h expected=%h", req, nib_in, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] v);
        @(posedge clk);
        nib_in = v;
        @(negedge clk);
    endtask

    initial begin
        // Reset state: input held at zero through reset (R6)
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 reset sign", sign_seg, 7'h00);
        check("R6 reset digit", digit_seg, 7'h3F);

        // Full table, both buses (R1, R2, R3, R4)
        for (int i = 0; i < N_VEC; i++) begin
            apply(VEC[i][17:14]);
            check("R1/R2 sign bus", sign_seg, VEC[i][13:7]);
            check("R4 digit bus", digit_seg, VEC[i][6:0]);
            check("R3 sign rest dark", {1'b0, sign_seg[5:0]}, 7'h00);
        end

        // R5: most negative value
        apply(4'b1000);
        check("R5 -8 digit", digit_seg, 7'h7F);
        check("R5 -8 sign", sign_seg, 7'h40);

        // R4: -1 exercises the invert-and-add path
        apply(4'b1111);
        check("R4 -1 digit", digit_seg, 7'h06);

        // R4: +3 with dark sign
        apply(4'b0011);
        check("R4 +3 digit", digit_seg, 7'h4F);
        check("R2 +3 sign", sign_seg, 7'h00);

        // R6: back to zero from a negative value
        apply(4'b1001);
        apply(4'b0000);
        check("R6 zero sign", sign_seg, 7'h00);
        check("R6 zero digit", digit_seg, 7'h3F);

        // R7: change between clock edges, observe before the next edge
        @(posedge clk);
        #(CLK_PERIOD/4);
        nib_in = 4'b1010;
        #1;
        check("R7 async sign", sign_seg, 7'h40);
        check("R7 async digit", digit_seg, 7'h7D);
        nib_in = 4'b0110;
        #1;
        check("R7 async digit 6", digit_seg, 7'h7D);
        check("R7 async sign off", sign_seg, 7'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule